// File: doc/BRIEF.md
# Serial EEPROM Sequential Instruction Fetcher

This block feeds program bytes to a processor core from up to eight two-wire serial EEPROMs. Each EEPROM holds 8 KB, and together they form one linear 64 KB space. The fetcher is the bus master and drives both lines as open-drain: an output enable pulls the line low, and the line level is read back on a separate input. To start a stream it sends a full random-read header. It then leaves the read stream open and lets the memory's internal pointer supply one byte after another.

The core raises `req` while it wants bytes. Each byte arrives with a one-cycle `byte_valid` strobe. When the core drops `req`, the fetcher parks the bus with SCL held low for as long as needed, and resumes the stream later without addressing again. A one-cycle `jump` loads a new 16-bit target address. The open stream is then closed, and the next fetch addresses the target. Closing works the same way when a sequential fetch is about to leave the current chip's 8 KB window.

The SCL rate is derived from the system clock. One quarter of an SCL period lasts ceil(CLK_HZ / (4*SCL_HZ)) clocks. The fetcher also waits in the high phase of each bit until SCL actually reads high.

Top module: `serial_rom_fetcher`

## Requirements
- R1: After reset both line enables are low (lines released), `byte_valid` and `ack_err` are low, and the first fetch reads address 0x0000.
- R2: An address phase is, in order: START; the control byte {DEV_TYPE (default 4'b1010), addr[15:13], 0}; the high byte {3'b000, addr[12:8]}; the low byte addr[7:0]; a repeated START; then the control byte with bit 0 set to 1. Each data byte is then shifted in MSB first.
- R3: Each fetched byte is presented on `byte_data` with a one-cycle `byte_valid` strobe and equals the memory content at the current address. The address then advances by one.
- R4: Within one chip, consecutive bytes are read with no new START. The master sends ACK (SDA low) for every byte after which it keeps reading.
- R5: While `req` is low after a byte, SCL is held low for an unlimited time and no byte is delivered. Raising `req` continues the same stream.
- R6: A `jump` pulse makes the next delivered bytes come from `jump_addr` onward. A byte whose read is in progress when the pulse arrives is dropped. The open stream is closed with NACK (SDA released) and then STOP before the new address phase.
- R7: When the next address is a multiple of 0x2000 (including the wrap from 0xFFFF to 0x0000), the stream is closed with NACK and STOP even if `req` is low. The next fetch addresses the new chip.
- R8: A missing ACK on any address-phase byte produces a one-cycle `ack_err` pulse, a STOP, and a retry from START with no action by the core.
- R9: Every interval in which SCL is released, and every interval in which it is pulled low, lasts at least two quarter periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core wants further bytes |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a fetched byte |
| byte_data | output | 8 | Fetched program byte |
| jump | input | 1 | One-cycle pulse: load a new fetch address |
| jump_addr | input | 16 | Target address taken on `jump` |
| ack_err | output | 1 | One-cycle pulse on a missing ACK during addressing |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | Level of the SCL line |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The bound checker watches several properties on every cycle:
- the minimum SCL high and low times;
- that strobes and error pulses last one cycle and occur only with SCL pulled low;
- that no byte is delivered in the cycle after a jump;
- that SCL stays low while a stall is in progress inside a chip window.

Other behaviours need a memory on the far side of the bus, so only the bench scenarios can show them:
- the order and content of the header bytes;
- the ACK and NACK counts;
- the number of START conditions per stream;
- chip switching at 8 KB boundaries and the wrap at the top of the 64 KB space;
- the dropped in-flight byte after a jump;
- retries after a refused control byte.

// File: rtl/serial_rom_fetcher.sv
module serial_rom_fetcher #(
  parameter int          CLK_HZ   = 125_000_000,
  parameter int          SCL_HZ   = 400_000,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  input  logic        jump,
  input  logic [15:0] jump_addr,
  output logic        ack_err,
  output logic        scl_oe,
  input  logic        scl_in,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int QTR = (CLK_HZ + 4*SCL_HZ - 1) / (4*SCL_HZ);
  localparam int CW  = (QTR > 1) ? $clog2(QTR) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_HOLD, S_MACK, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] qcnt;
  logic [1:0]  ph, seq;
  logic [3:0]  bcnt;
  logic [7:0]  sh;
  logic [15:0] pc, tgt;
  logic        pend, rtry, do_ack, ackd, scl_lo, sda_lo;
  logic        tick, go;

  assign tick   = (qcnt == CW'(QTR-1));
  assign go     = tick && !(ph == 2'd2 && !scl_in);
  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;

  function automatic logic [7:0] byte_for(input logic [1:0] s, input logic [15:0] a);
    case (s)
      2'd0:    return {DEV_TYPE, a[15:13], 1'b0};
      2'd1:    return {3'b000, a[12:8]};
      2'd2:    return a[7:0];
      default: return {DEV_TYPE, a[15:13], 1'b1};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qcnt <= '0;
      ph <= 2'd0;
      seq <= 2'd0;
      bcnt <= 4'd0;
      sh <= 8'h00;
      pc <= 16'h0000;
      tgt <= 16'h0000;
      pend <= 1'b0;
      rtry <= 1'b0;
      do_ack <= 1'b0;
      ackd <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
      byte_valid <= 1'b0;
      byte_data <= 8'h00;
      ack_err <= 1'b0;
    end else begin
      qcnt <= tick ? '0 : qcnt + 1'b1;
      byte_valid <= 1'b0;
      ack_err <= 1'b0;
      if (go) begin
        case (st)
          S_IDLE: begin
            if (pend) begin
              pc <= tgt;
              pend <= 1'b0;
            end
            if (req || rtry) begin
              st <= S_START;
              seq <= 2'd0;
              rtry <= 1'b0;
            end
          end
          S_START: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1;
                sh <= byte_for(seq, pc);
                bcnt <= 4'd0;
                st <= S_TX;
              end
            endcase
          end
          S_TX: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= (bcnt == 4'd8) ? 1'b0 : ~sh[7];
              2'd1: scl_lo <= 1'b0;
              2'd2: ackd <= ~sda_in;
              default: begin
                scl_lo <= 1'b1;
                if (bcnt != 4'd8) begin
                  sh <= {sh[6:0], 1'b0};
                  bcnt <= bcnt + 4'd1;
                end else if (!ackd) begin
                  ack_err <= 1'b1;
                  rtry <= 1'b1;
                  st <= S_STOP;
                end else begin
                  bcnt <= 4'd0;
                  seq <= seq + 2'd1;
                  case (seq)
                    2'd0, 2'd1: sh <= byte_for(seq + 2'd1, pc);
                    2'd2: st <= S_START;
                    default: st <= S_RX;
                  endcase
                end
              end
            endcase
          end
          S_RX: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sh <= {sh[6:0], sda_in};
              default: begin
                scl_lo <= 1'b1;
                bcnt <= bcnt + 4'd1;
                if (bcnt == 4'd7) begin
                  st <= S_HOLD;
                  if (!pend && !jump) begin
                    byte_valid <= 1'b1;
                    byte_data <= sh;
                    pc <= pc + 16'd1;
                  end
                end
              end
            endcase
          end
          S_HOLD: begin
            if (pend || pc[12:0] == 13'd0) begin
              do_ack <= 1'b0;
              st <= S_MACK;
            end else if (req) begin
              do_ack <= 1'b1;
              st <= S_MACK;
            end
          end
          S_MACK: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= do_ack;
              2'd1: scl_lo <= 1'b0;
              2'd2: ;
              default: begin
                scl_lo <= 1'b1;
                bcnt <= 4'd0;
                st <= do_ack ? S_RX : S_STOP;
              end
            endcase
          end
          default: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: st <= S_IDLE;
            endcase
          end
        endcase
      end
      if (jump) begin
        tgt <= jump_addr;
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetcher_checks.sv
module fetcher_checks #(
  parameter int CLK_HZ = 125_000_000,
  parameter int SCL_HZ = 400_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        jump,
  input logic [15:0] jump_addr,
  input logic        byte_valid,
  input logic        ack_err,
  input logic        scl_oe
);
  localparam int QTR = (CLK_HZ + 4*SCL_HZ - 1) / (4*SCL_HZ);

  int          hi_cnt, lo_cnt;
  logic [15:0] cp;
  logic        stalled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      lo_cnt <= 0;
      cp <= 16'h0000;
      stalled <= 1'b0;
    end else begin
      hi_cnt <= scl_oe ? 0 : ((hi_cnt < 4*QTR) ? hi_cnt + 1 : hi_cnt);
      lo_cnt <= !scl_oe ? 0 : ((lo_cnt < 4*QTR) ? lo_cnt + 1 : lo_cnt);
      if (jump) begin
        cp <= jump_addr;
        stalled <= 1'b0;
      end else if (byte_valid) begin
        cp <= cp + 16'd1;
        stalled <= 1'b1;
      end else if (req) begin
        stalled <= 1'b0;
      end
    end
  end

  p_strobe_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> scl_oe);
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !req && !jump && ((cp & 16'h1FFF) != 16'h0000)) |-> scl_oe);
  p_jump_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !$past(jump));
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (scl_oe && !byte_valid));
  p_err_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> !ack_err);
  p_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (hi_cnt >= 2*QTR - 1));
  p_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> (lo_cnt >= 2*QTR - 1));
endmodule

bind serial_rom_fetcher fetcher_checks #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) i_chk (.*);

// File: tb/test_serial_rom_fetcher.sv
module test_serial_rom_fetcher;
  localparam int CLK_F = 125_000_000;
  localparam int SCL_F = 1_000_000;
  localparam int QT    = (CLK_F + 4*SCL_F - 1) / (4*SCL_F);

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, jump = 1'b0;
  logic [15:0] jump_addr = 16'h0000;
  logic byte_valid, ack_err, scl_oe, sda_oe;
  logic [7:0] byte_data;
  logic s_sda_low = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | s_sda_low);

  always #4 clk = ~clk;

  serial_rom_fetcher #(.CLK_HZ(CLK_F), .SCL_HZ(SCL_F)) i_serial_rom_fetcher (
    .clk(clk), .rst_n(rst_n), .req(req), .byte_valid(byte_valid), .byte_data(byte_data),
    .jump(jump), .jump_addr(jump_addr), .ack_err(ack_err),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line));

  int checks = 0, fails = 0, cyc = 0, vcnt = 0, errs = 0;
  logic [15:0] exp_pc = 16'h0000;

  function automatic logic [7:0] romv(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd37) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model on the bus: eight 8 KB chips
  int starts = 0, stops = 0, acks = 0, nacks = 0, fail_n = 0;
  int smode = 0, bn = 0, bidx = 0;
  logic [7:0] ssh = 8'h00, cur = 8'h00, last_wr = 8'h00, last_rd = 8'h00, last_hi = 8'h00, last_lo = 8'h00;
  logic [2:0] chip = 3'd0;
  logic [12:0] ptr = 13'd0;
  logic rdmode = 1'b0, mack = 1'b0;

  always @(negedge sda_line) if (scl_line) begin
    starts++; smode = 1; bn = 0; bidx = 0; rdmode = 1'b0; s_sda_low = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stops++; smode = 0; s_sda_low = 1'b0;
  end
  always @(posedge scl_line) begin
    if (smode == 1 && bn < 8) begin
      ssh = {ssh[6:0], sda_line}; bn++;
    end else if (smode == 2) begin
      if (bn < 8) bn++;
      else if (bn == 8) begin
        mack = !sda_line;
        if (mack) acks++; else nacks++;
        bn = 9;
      end
    end
  end
  always @(negedge scl_line) begin
    if (smode == 1) begin
      if (bn == 8) begin
        bit ok;
        ok = 1'b1;
        case (bidx)
          0: begin
            if (ssh[7:4] != 4'hA || fail_n > 0) begin
              ok = 1'b0;
              if (fail_n > 0) fail_n--;
            end else begin
              chip = ssh[3:1]; rdmode = ssh[0];
              if (ssh[0]) last_rd = ssh; else last_wr = ssh;
            end
          end
          1: begin ptr[12:8] = ssh[4:0]; last_hi = ssh; end
          2: begin ptr[7:0] = ssh; last_lo = ssh; end
          default: ok = 1'b0;
        endcase
        if (ok) begin s_sda_low = 1'b1; bn = 9; end
        else smode = 0;
      end else if (bn == 9) begin
        s_sda_low = 1'b0; bn = 0; bidx++;
        if (rdmode) begin
          smode = 2; cur = romv({chip, ptr}); s_sda_low = ~cur[7];
        end
      end
    end else if (smode == 2) begin
      if (bn > 0 && bn < 8) s_sda_low = ~cur[7-bn];
      else if (bn == 8) s_sda_low = 1'b0;
      else if (bn == 9) begin
        if (mack) begin
          ptr = ptr + 13'd1; cur = romv({chip, ptr}); s_sda_low = ~cur[7]; bn = 0;
        end else begin
          smode = 0; s_sda_low = 1'b0;
        end
      end
    end
  end

  // reference model, compared on every clock
  int hrun = 0, lrun = 0, min_hi = 1_000_000, min_lo = 1_000_000;
  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      check(byte_data == romv(exp_pc), "R3", "fetched byte", byte_data, romv(exp_pc));
      exp_pc = exp_pc + 16'd1;
      vcnt++;
    end
    if (ack_err) errs++;
    if (scl_line) begin
      if (lrun > 0 && lrun < min_lo) min_lo = lrun;
      lrun = 0; hrun++;
    end else begin
      if (hrun > 0 && hrun < min_hi) min_hi = hrun;
      hrun = 0; lrun++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190_000) begin
      fails++;
      $display("FAIL R5 watchdog: cycles %0d expected below %0d", cyc, 190_000);
      finish_run();
    end
  end

  task automatic fetch(input int n);
    int target;
    target = vcnt + n;
    req = 1'b1;
    while (vcnt < target) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_jump(input logic [15:0] a);
    @(negedge clk);
    jump = 1'b1; jump_addr = a; exp_pc = a;
    @(negedge clk);
    jump = 1'b0;
  endtask

  initial begin
    int s0, n0, k0, v0, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
    check(!byte_valid && !ack_err, "R1", "strobes idle", {byte_valid, ack_err}, 0);

    fetch(6);
    check(starts == 2, "R2", "starts for first stream", starts, 2);
    check(last_wr == 8'hA0, "R2", "write control byte", last_wr, 8'hA0);
    check(last_rd == 8'hA1, "R2", "read control byte", last_rd, 8'hA1);
    check(last_hi == 8'h00 && last_lo == 8'h00, "R1", "first address", {last_hi, last_lo}, 0);

    bad = 0; v0 = vcnt;
    repeat (3000) begin
      @(negedge clk);
      if (!scl_oe) bad++;
    end
    check(bad == 0, "R5", "SCL released during stall", bad, 0);
    check(vcnt == v0, "R5", "bytes during stall", vcnt, v0);

    fetch(3);
    check(starts == 2, "R4", "no restart in stream", starts, 2);
    check(acks == 8, "R4", "master acks", acks, 8);

    s0 = starts; n0 = nacks;
    do_jump(16'h1FFC);
    fetch(8);
    check(nacks == n0 + 2, "R6", "nacks for jump and crossing", nacks, n0 + 2);
    check(starts == s0 + 4, "R7", "starts after jump and crossing", starts, s0 + 4);
    check(last_rd == 8'hA3, "R7", "chip 1 read control", last_rd, 8'hA3);

    do_jump(16'h3FFC);
    fetch(4);
    s0 = stops; k0 = nacks;
    repeat (1500) @(negedge clk);
    check(stops == s0 + 1, "R7", "stop at boundary with req low", stops, s0 + 1);
    check(nacks == k0 + 1, "R7", "nack at boundary", nacks, k0 + 1);
    check(!scl_oe && !sda_oe, "R7", "bus free after boundary", {scl_oe, sda_oe}, 0);
    fetch(2);
    check(last_rd == 8'hA5, "R7", "chip 2 read control", last_rd, 8'hA5);

    do_jump(16'hFFFE);
    fetch(3);
    check(last_rd == 8'hA1 && last_hi == 8'h00 && last_lo == 8'h00, "R7", "wrap to chip 0",
          {last_rd, last_hi, last_lo}, 24'hA10000);

    v0 = vcnt;
    req = 1'b1;
    while (vcnt < v0 + 1) @(negedge clk);
    repeat (300) @(negedge clk);
    do_jump(16'h0123);
    while (vcnt < v0 + 3) @(negedge clk);
    req = 1'b0;
    check(last_hi == 8'h01 && last_lo == 8'h23, "R6", "mid-byte jump address", {last_hi, last_lo}, 16'h0123);
    check(last_wr == 8'hA0, "R2", "write control after jump", last_wr, 8'hA0);

    fail_n = 2; s0 = starts; k0 = errs;
    do_jump(16'h0500);
    fetch(2);
    check(errs == k0 + 2, "R8", "error pulses", errs, k0 + 2);
    check(starts == s0 + 4, "R8", "starts with retries", starts, s0 + 4);

    check(min_hi >= 2*QT - 1, "R9", "min SCL high", min_hi, 2*QT);
    check(min_lo >= 2*QT - 1, "R9", "min SCL low", min_lo, 2*QT);
    finish_run();
  end
endmodule